// File: doc/BRIEF.md
# Banked Interrupt Controller with Normal/Fast Steering

This block gathers level-sensitive interrupt requests from 96 sources, arranged as three banks of 32, and presents them to a processor as two registered request lines. One is a normal request and one is a fast request. Source number n lives in bank n/32 at bit n%32.

Each source has four per-bank controls: an enable bit, a mask bit, a steering bit, and a pending view. A source counts only when its enable bit is 1 and its mask bit is 0. The steering bit then sends it to either the normal path or the fast path. Each path has its own pending banks, and its request line is the OR of those banks. A vector register gives the index of the lowest-numbered normal-path pending source.

Source 0 is different. It is fed from an external non-maskable pin through a programmable trigger detector and a sticky latch. Software clears that latch by writing 1 to bit 0 of normal pending bank 0. A base-address word and a one-bit protection flag are plain storage for software.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Registers sit at fixed byte offsets:
  - 0x00: vector (read-only)
  - 0x04: base word
  - 0x08: protection flag
  - 0x0C: trigger control
  - 0x10/0x14/0x18: normal pending, banks 0..2
  - 0x20/0x24/0x28: fast pending, banks 0..2
  - 0x30/0x34/0x38: steering, banks 0..2
  - 0x40/0x44/0x48: enable, banks 0..2
  - 0x50/0x54/0x58: mask, banks 0..2

  Steering, enable and mask banks read back what was last written.
- R2: Source n appears at bank n/32, bit n%32. Its pending bit is 1 only while the source is active, its enable bit is 1 and its mask bit is 0.
- R3: A mask bit of 1 blocks its source even when that source is enabled.
- R4: A steering bit of 0 routes the source to the normal pending bank and normal request line. A steering bit of 1 routes it to the fast pending bank and fast request line. A source never shows in both pending banks at once.
- R5: The vector register reads the index of the lowest-numbered set bit across the normal pending banks, searching from bank 0 bit 0 upward. It reads 0 when nothing is pending.
- R6: Source 0 is a sticky latch set by the external pin's trigger condition. Writing 1 to bit 0 of normal pending bank 0 clears it, provided the trigger condition is not present in that same cycle. Writing 0 there, or writing any other bit, leaves it unchanged.
- R7: Trigger control bits [1:0] select the trigger condition: 0 = high level (the reset default), 1 = low level, 2 = rising edge, 3 = falling edge.
- R8: Once every enable bank is 0 and every mask bank is all-ones, neither request line asserts, whatever the sources do.
- R9: Each request line is the OR of its path's pending bits. The request lines and the pending banks are registered: a change on a source input shows at the outputs after one clock edge.
- R10: After reset, all registers read 0 except the mask banks, which read all-ones, and both request lines are 0.
- R11: The protection register stores only bit 0, and its other bits read 0. The base word stores all 32 bits. Pending banks other than the bit-0 clear ignore writes. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| nmi_i | input | 1 | External non-maskable source (source 0) |
| src_i | input | 95 | Level sources 1..95 (bit n is source n) |
| irq_o | output | 1 | Registered normal request |
| fiq_o | output | 1 | Registered fast request |

## Verification
The assertions assume that reset is held on the first clock edge. They also assume that source inputs and register writes change only between clock edges, so every registered view follows one edge behind its inputs.

The stimulus drives all inputs at the falling edge. It then waits at least two rising edges before it reads a pending bank, the vector or a request line, except in the latency check, which samples on purpose both before and after the single edge. Trigger-mode changes are made while the external pin is at a level that does not itself fire the newly chosen condition, unless the test needs that condition.

// File: rtl/bic_pkg.sv
package bic_pkg;
    localparam int BANK_W = 32;

    // register group, taken from address bits [7:4]
    typedef enum logic [3:0] {
        GRP_MISC = 4'h0,
        GRP_IRQP = 4'h1,
        GRP_FIQP = 4'h2,
        GRP_SEL  = 4'h3,
        GRP_EN   = 4'h4,
        GRP_MASK = 4'h5
    } grp_e;

    // word slots inside the misc group, taken from address bits [3:2]
    typedef enum logic [1:0] {
        MISC_VEC  = 2'd0,
        MISC_BASE = 2'd1,
        MISC_PROT = 2'd2,
        MISC_TRIG = 2'd3
    } misc_e;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef struct packed {
        logic [31:0] base;
        logic        prot;
        trig_e       trig;
    } ctl_t;

    localparam ctl_t CTL_RST = '{base: 32'h0, prot: 1'b0, trig: TRIG_HIGH};

    function automatic logic is_known_grp(input logic [3:0] g);
        return g <= 4'h5;
    endfunction

    function automatic logic [1:0] slot_of(input logic [7:0] a);
        return a[3:2];
    endfunction
endpackage

// File: rtl/bic_nmi.sv
module bic_nmi
    import bic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    input  trig_e trig,
    input  logic  clr,
    output logic  latch
);
    logic prev_q;
    logic hit;

    always_comb begin
        unique case (trig)
            TRIG_HIGH: hit = pin;
            TRIG_LOW:  hit = !pin;
            TRIG_RISE: hit = pin && !prev_q;
            TRIG_FALL: hit = !pin && prev_q;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            latch  <= 1'b0;
        end else begin
            prev_q <= pin;
            if (hit)
                latch <= 1'b1;
            else if (clr)
                latch <= 1'b0;
        end
    end

    // R6: without a clear the latch stays set
    p_nmi_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        latch && !clr |=> latch);
    // R6: a clear leaves the latch set only when the trigger fired in that cycle
    p_nmi_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr && latch && !hit |=> !latch);
endmodule

// File: rtl/bic_prio.sv
module bic_prio #(
    parameter int N = 96,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R5: no lower-numbered request is set below the chosen index
    always_comb begin
        if (found)
            p_prio_lowest_r5: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
    end
endmodule

// File: rtl/bic_regs.sv
module bic_regs
    import bic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int NS = NUM_BANKS * BANK_W,
    localparam int IW = $clog2(NS),
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [NS-1:0] irq_pend,
    input  logic [NS-1:0] fiq_pend,
    input  logic [IW-1:0] vec_idx,
    output logic [NS-1:0] en_flat,
    output logic [NS-1:0] mask_flat,
    output logic [NS-1:0] sel_flat,
    output ctl_t          ctl,
    output logic          nmi_clr
);
    logic [BANK_W-1:0] en_q   [NUM_BANKS];
    logic [BANK_W-1:0] mask_q [NUM_BANKS];
    logic [BANK_W-1:0] sel_q  [NUM_BANKS];

    grp_e    grp;
    logic [1:0] slot;
    logic    bank_ok;
    logic [BW-1:0] bank;

    assign grp     = grp_e'(addr[7:4]);
    assign slot    = slot_of(addr);
    assign bank_ok = is_known_grp(addr[7:4]) && (int'(slot) < NUM_BANKS);
    assign bank    = BW'(slot);

    assign nmi_clr = wr_en && (grp == GRP_IRQP) && (slot == 2'd0) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                en_q[b]   <= '0;
                mask_q[b] <= '1;
                sel_q[b]  <= '0;
            end
            ctl <= CTL_RST;
        end else if (wr_en) begin
            unique case (grp)
                GRP_SEL:  if (bank_ok) sel_q[bank]  <= wdata;
                GRP_EN:   if (bank_ok) en_q[bank]   <= wdata;
                GRP_MASK: if (bank_ok) mask_q[bank] <= wdata;
                GRP_MISC: begin
                    unique case (misc_e'(slot))
                        MISC_BASE: ctl.base <= wdata;
                        MISC_PROT: ctl.prot <= wdata[0];
                        MISC_TRIG: ctl.trig <= trig_e'(wdata[1:0]);
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
        assign en_flat[b*BANK_W +: BANK_W]   = en_q[b];
        assign mask_flat[b*BANK_W +: BANK_W] = mask_q[b];
        assign sel_flat[b*BANK_W +: BANK_W]  = sel_q[b];
    end

    always_comb begin
        rdata = '0;
        unique case (grp)
            GRP_MISC: begin
                unique case (misc_e'(slot))
                    MISC_VEC:  rdata = 32'(vec_idx);
                    MISC_BASE: rdata = ctl.base;
                    MISC_PROT: rdata = {31'b0, ctl.prot};
                    MISC_TRIG: rdata = {30'b0, ctl.trig};
                    default: ;
                endcase
            end
            GRP_IRQP: if (bank_ok) rdata = irq_pend[int'(bank)*BANK_W +: BANK_W];
            GRP_FIQP: if (bank_ok) rdata = fiq_pend[int'(bank)*BANK_W +: BANK_W];
            GRP_SEL:  if (bank_ok) rdata = sel_q[bank];
            GRP_EN:   if (bank_ok) rdata = en_q[bank];
            GRP_MASK: if (bank_ok) rdata = mask_q[bank];
            default: ;
        endcase
    end

    // R10: the first cycle after reset shows all mask bits set and no enables
    p_reset_vals_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_flat == '1) && (en_flat == '0) && (sel_flat == '0));
    // R11: a write to an unmapped group changes no enable bit
    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en && !is_known_grp(addr[7:4]) |=> $stable(en_flat));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import bic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int NS = NUM_BANKS * BANK_W,
    localparam int IW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          nmi_i,
    input  logic [NS-1:1] src_i,
    output logic          irq_o,
    output logic          fiq_o
);
    logic [NS-1:0] en_flat, mask_flat, sel_flat;
    logic [NS-1:0] raw, gated;
    logic [NS-1:0] irq_pend_q, fiq_pend_q;
    logic [IW-1:0] vec_idx;
    logic          vec_found;
    logic          nmi_latch, nmi_clr;
    ctl_t          ctl;

    bic_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_pend  (irq_pend_q),
        .fiq_pend  (fiq_pend_q),
        .vec_idx   (vec_idx),
        .en_flat   (en_flat),
        .mask_flat (mask_flat),
        .sel_flat  (sel_flat),
        .ctl       (ctl),
        .nmi_clr   (nmi_clr)
    );

    bic_nmi u_nmi (
        .clk   (clk),
        .rst   (rst),
        .pin   (nmi_i),
        .trig  (ctl.trig),
        .clr   (nmi_clr),
        .latch (nmi_latch)
    );

    assign raw   = {src_i, nmi_latch};
    assign gated = raw & en_flat & ~mask_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend_q <= '0;
            fiq_pend_q <= '0;
            irq_o      <= 1'b0;
            fiq_o      <= 1'b0;
        end else begin
            irq_pend_q <= gated & ~sel_flat;
            fiq_pend_q <= gated & sel_flat;
            irq_o      <= |(gated & ~sel_flat);
            fiq_o      <= |(gated & sel_flat);
        end
    end

    bic_prio #(.N(NS)) u_prio (
        .req   (irq_pend_q),
        .found (vec_found),
        .idx   (vec_idx)
    );

    // R4: steering puts a source in one pending bank only
    p_path_disjoint_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_pend_q & fiq_pend_q) == '0);
    // R5: a found vector points at a set normal pending bit
    p_vec_points_r5: assert property (@(posedge clk) disable iff (rst)
        vec_found |-> irq_pend_q[vec_idx]);
    // R5: nothing pending reads vector 0
    p_vec_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !vec_found |-> vec_idx == '0);
    // R8: with every enable cleared, both lines drop on the next edge
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (en_flat == '0) |=> !irq_o && !fiq_o);
    // R9: request lines agree with their pending banks
    p_line_or_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_o == (|irq_pend_q)) && (fiq_o == (|fiq_pend_q)));
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
    localparam logic [7:0] A_VEC = 8'h00, A_BASE = 8'h04, A_PROT = 8'h08, A_TRIG = 8'h0C;
    localparam logic [7:0] A_IRQ = 8'h10, A_FIQ = 8'h20, A_SEL = 8'h30, A_EN = 8'h40, A_MSK = 8'h50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic nmi_i = 1'b0;
    logic [95:1] src = '0;
    logic irq_o, fiq_o;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .nmi_i(nmi_i), .src_i(src), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic int lowest(input logic [95:0] v);
        for (int i = 0; i < 96; i++) if (v[i]) return i;
        return 0;
    endfunction

    logic [31:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state of every register and both lines
        for (int b = 0; b < 3; b++) begin
            rd(A_MSK + 8'(4*b), r); chk("R10 mask reset", r, 32'hFFFF_FFFF);
            rd(A_EN + 8'(4*b), r);  chk("R10 enable reset", r, 32'h0);
            rd(A_SEL + 8'(4*b), r); chk("R10 select reset", r, 32'h0);
            rd(A_IRQ + 8'(4*b), r); chk("R10 irq pend reset", r, 32'h0);
            rd(A_FIQ + 8'(4*b), r); chk("R10 fiq pend reset", r, 32'h0);
        end
        for (int a = 0; a < 4; a++) begin
            rd(8'(4*a), r); chk("R10 misc reset", r, 32'h0);
        end
        chk("R10 irq_o reset", {31'b0, irq_o}, 32'h0);
        chk("R10 fiq_o reset", {31'b0, fiq_o}, 32'h0);

        // R1: read-back of distinct patterns at each bank offset
        for (int b = 0; b < 3; b++) begin
            wr(A_SEL + 8'(4*b), 32'h5A00_0000 + 32'(b));
            wr(A_EN + 8'(4*b), 32'hA500_0010 + 32'(b));
            wr(A_MSK + 8'(4*b), 32'h0F00_0020 + 32'(b));
        end
        for (int b = 0; b < 3; b++) begin
            rd(A_SEL + 8'(4*b), r); chk("R1 select readback", r, 32'h5A00_0000 + 32'(b));
            rd(A_EN + 8'(4*b), r);  chk("R1 enable readback", r, 32'hA500_0010 + 32'(b));
            rd(A_MSK + 8'(4*b), r); chk("R1 mask readback", r, 32'h0F00_0020 + 32'(b));
        end

        // R11: base, protection, unmapped and read-only pending
        wr(A_BASE, 32'hDEAD_BEEF); rd(A_BASE, r); chk("R11 base store", r, 32'hDEAD_BEEF);
        wr(A_PROT, 32'hFFFF_FFFF); rd(A_PROT, r); chk("R11 prot bit0 only", r, 32'h1);
        wr(A_PROT, 32'h0);         rd(A_PROT, r); chk("R11 prot clear", r, 32'h0);
        wr(8'h2C, 32'hFFFF_FFFF);  rd(8'h2C, r);  chk("R11 unmapped read", r, 32'h0);
        wr(8'h60, 32'hFFFF_FFFF);  rd(8'h60, r);  chk("R11 unmapped group", r, 32'h0);
        rd(A_EN, r); chk("R11 unmapped write no effect", r, 32'hA500_0010);

        // open every source on the normal path
        for (int b = 0; b < 3; b++) begin
            wr(A_SEL + 8'(4*b), 32'h0);
            wr(A_EN + 8'(4*b), 32'hFFFF_FFFF);
            wr(A_MSK + 8'(4*b), 32'h0);
        end
        wr(A_IRQ + 8'h4, 32'hFFFF_FFFF);
        settle();
        rd(A_IRQ + 8'h4, r); chk("R11 pending write ignored", r, 32'h0);
        chk("R10 idle irq_o", {31'b0, irq_o}, 32'h0);
        rd(A_VEC, r); chk("R5 vector idle zero", r, 32'h0);

        // R2/R4/R5: walk every level source through both paths
        for (int n = 1; n < 96; n++) begin
            @(negedge clk); src = '0; src[n] = 1'b1;
            settle();
            rd(A_IRQ + 8'(4*(n/32)), r); chk("R2 bank/bit position", r, 32'(1) << (n%32));
            rd(A_VEC, r); chk("R5 single vector", r, 32'(n));
            chk("R4 irq_o on normal path", {30'b0, fiq_o, irq_o}, 32'h1);
            wr(A_SEL + 8'(4*(n/32)), 32'(1) << (n%32));
            settle();
            rd(A_FIQ + 8'(4*(n/32)), r); chk("R4 fast bank position", r, 32'(1) << (n%32));
            rd(A_IRQ + 8'(4*(n/32)), r); chk("R4 normal bank empty", r, 32'h0);
            rd(A_VEC, r); chk("R5 vector ignores fast path", r, 32'h0);
            chk("R4 fiq_o on fast path", {30'b0, fiq_o, irq_o}, 32'h2);
            wr(A_SEL + 8'(4*(n/32)), 32'h0);
        end

        // R5: several sources at once
        for (int k = 0; k < 8; k++) begin
            logic [95:0] pat;
            pat = '0;
            pat[95 - 7*k] = 1'b1;
            pat[33 + 5*k] = 1'b1;
            pat[1 + 9*k] = (k % 2 == 0);
            @(negedge clk); src = pat[95:1];
            settle();
            rd(A_VEC, r); chk("R5 lowest wins", r, 32'(lowest(pat)));
        end

        // R9: one edge from source to line
        @(negedge clk); src = '0;
        settle();
        @(negedge clk); src[70] = 1'b1;
        #1 chk("R9 before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R9 after one edge", {31'b0, irq_o}, 32'h1);
        rd(A_IRQ + 8'h8, r); chk("R9 pending registered", r, 32'(1) << 6);

        // R3: mask overrides enable
        wr(A_MSK + 8'h8, 32'(1) << 6);
        settle();
        chk("R3 masked line", {31'b0, irq_o}, 32'h0);
        rd(A_IRQ + 8'h8, r); chk("R3 masked pending", r, 32'h0);
        wr(A_MSK + 8'h8, 32'h0);
        wr(A_EN + 8'h8, 32'hFFFF_FFBF);
        settle();
        chk("R2 disabled source", {31'b0, irq_o}, 32'h0);
        wr(A_EN + 8'h8, 32'hFFFF_FFFF);
        @(negedge clk); src = '0;

        // R6: sticky latch of source 0 in the default high-level mode
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); nmi_i = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_IRQ, r); chk("R6 latched pending", r, 32'h1);
        chk("R6 latched line", {31'b0, irq_o}, 32'h1);
        wr(A_IRQ, 32'hFFFF_FFFE);
        settle();
        rd(A_IRQ, r); chk("R6 other bits do not clear", r, 32'h1);
        wr(A_IRQ, 32'h1);
        settle();
        rd(A_IRQ, r); chk("R6 write 1 clears", r, 32'h0);
        chk("R6 line drops", {31'b0, irq_o}, 32'h0);

        // R7: rising edge mode
        wr(A_TRIG, 32'h2);
        rd(A_TRIG, r); chk("R7 trig readback", r, 32'h2);
        @(negedge clk); nmi_i = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_IRQ, r); chk("R7 rising sets", r, 32'h1);
        wr(A_IRQ, 32'h1);
        settle();
        rd(A_IRQ, r); chk("R7 held high no new edge", r, 32'h0);
        // falling edge mode
        wr(A_TRIG, 32'h3);
        settle();
        rd(A_IRQ, r); chk("R7 falling idle", r, 32'h0);
        @(negedge clk); nmi_i = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_IRQ, r); chk("R7 falling sets", r, 32'h1);
        wr(A_IRQ, 32'h1);
        settle();
        rd(A_IRQ, r); chk("R7 low no new fall", r, 32'h0);
        // low level mode: a clear cannot win while the pin stays low
        wr(A_TRIG, 32'h1);
        settle();
        wr(A_IRQ, 32'h1);
        settle();
        rd(A_IRQ, r); chk("R7 low level holds", r, 32'h1);
        @(negedge clk); nmi_i = 1'b1;
        wr(A_IRQ, 32'h1);
        settle();
        rd(A_IRQ, r); chk("R7 low level released", r, 32'h0);
        wr(A_TRIG, 32'h0);

        // R8: fully closed controller stays silent
        for (int b = 0; b < 3; b++) begin
            wr(A_EN + 8'(4*b), 32'h0);
            wr(A_MSK + 8'(4*b), 32'hFFFF_FFFF);
        end
        @(negedge clk); src = '1; nmi_i = 1'b1;
        for (int b = 0; b < 3; b++) wr(A_SEL + 8'(4*b), 32'hAAAA_AAAA);
        settle();
        chk("R8 lines silent", {30'b0, fiq_o, irq_o}, 32'h0);
        for (int b = 0; b < 3; b++) begin
            rd(A_IRQ + 8'(4*b), r); chk("R8 normal pend silent", r, 32'h0);
            rd(A_FIQ + 8'(4*b), r); chk("R8 fast pend silent", r, 32'h0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule